// File: doc/BRIEF.md
# Per-Pin Selectable Input Debounce Filter

This block sits between the synchronised input pins of a 32-pin general-purpose I/O bank and the logic that reads them: the value register and the interrupt detectors. Each pin has a 2-bit selector. The selector either lets the pin bypass filtering or picks one of three programmable debounce periods that all pins share. When filtering is on, a pin's filtered output takes a new level only after the raw input has held that level for the chosen number of clock cycles. Shorter pulses are dropped.

The selector bits sit in two write-only select registers, one for the high bits and one for the low bits. The three periods sit in three further registers. All five are written over a simple register port that has an address and a write strobe. Any master may rewrite this configuration at any time. Each pin has its own counter and its own candidate level, so a pin is filtered independently of the others, even when several pins share a period.

Top module: `gpio_dbnc_filter`

## Requirements
- R1: While `rstN` is low, `filtOut` is all zeros, and every selector and every period is cleared to 0.
- R2: The selector of pin i is `{selHi[i], selLo[i]}`. A write to address 0 loads `selHi` and a write to address 1 loads `selLo`, each from `regWrData[NUM_PINS-1:0]`.
- R3: A pin whose selector is 0 bypasses filtering. Its `filtOut` bit equals the `rawIn` value sampled at the previous rising edge.
- R4: Addresses 2, 3 and 4 load the periods used by selector values 1, 2 and 3, taken from `regWrData[CNT_W-1:0]`. A period is a count of clock cycles, and all pins that select it share it.
- R5: With a nonzero period P, a new raw level reaches `filtOut` at the rising edge that samples it for the (P+1)-th consecutive time.
- R6: A raw level that differs from the filtered output for P or fewer consecutive samples and then returns leaves `filtOut` unchanged.
- R7: A nonzero selector whose period is 0 behaves like bypass (R3).
- R8: At the edge where a write changes a pin's selector bit, that pin's output holds its value and its counter restarts. The new selector applies from the following edge.
- R9: Writes to addresses 5, 6 and 7 change no selector and no period.
- R10: After `rstN` rises with the raw inputs held steady, `filtOut` equals `rawIn` by the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address (0 selHi, 1 selLo, 2..4 periods) |
| regWrData | input | DATA_W | Register write data |
| rawIn | input | NUM_PINS | Synchronised raw pin levels |
| filtOut | output | NUM_PINS | Filtered pin levels |

## Verification
The bench goes after the off-by-one boundary of the counter. It holds a level for exactly P samples, which must be rejected, and for P+1 samples, which must be accepted. A design that compared against P-1 or P+1 would let one pulse through or drop the other. The bench also changes selectors while a count is running: a design that did not restart the counter would commit a stale candidate, and one that updated the output on the restart edge would show a glitch. A period of 0 under a nonzero selector and writes to the unused addresses are also exercised. A design that stalled forever on a zero period, or decoded the address loosely, would part from the reference model in the next few cycles.

// File: rtl/gpio_dbnc_pkg.sv
package gpio_dbnc_pkg;

  // Two selector bits give bypass plus three shared periods
  localparam int unsigned NUM_TIMERS = 3;

  typedef enum logic [2:0] {
    REG_SEL_HI = 3'd0,
    REG_SEL_LO = 3'd1,
    REG_PER_A  = 3'd2,
    REG_PER_B  = 3'd3,
    REG_PER_C  = 3'd4
  } regAddr_e;

  // Per-pin strobe bundle from control to datapath
  typedef struct packed {
    logic       restart;
    logic [1:0] sel;
  } pinCtrl_t;

endpackage

// File: rtl/gpio_dbnc_ctrl.sv
module gpio_dbnc_ctrl
  import gpio_dbnc_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              regWrEn,
  input  logic [2:0]                        regAddr,
  input  logic [DATA_W-1:0]                 regWrData,
  output pinCtrl_t [NUM_PINS-1:0]           pinCtrl,
  output logic [NUM_TIMERS:1][CNT_W-1:0]    periods
);

  logic [NUM_PINS-1:0] selHi, selLo, nextHi, nextLo, restartVec;
  logic [DATA_W-1:0]   unusedData;
  logic                hiWr, loWr;

  assign unusedData = regWrData;
  assign hiWr = regWrEn && (regAddr == REG_SEL_HI);
  assign loWr = regWrEn && (regAddr == REG_SEL_LO);

  always_comb begin
    nextHi     = hiWr ? regWrData[NUM_PINS-1:0] : selHi;
    nextLo     = loWr ? regWrData[NUM_PINS-1:0] : selLo;
    restartVec = (nextHi ^ selHi) | (nextLo ^ selLo);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selHi   <= '0;
      selLo   <= '0;
      periods <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        REG_SEL_HI: selHi      <= regWrData[NUM_PINS-1:0];
        REG_SEL_LO: selLo      <= regWrData[NUM_PINS-1:0];
        REG_PER_A:  periods[1] <= regWrData[CNT_W-1:0];
        REG_PER_B:  periods[2] <= regWrData[CNT_W-1:0];
        REG_PER_C:  periods[3] <= regWrData[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pinCtrl
    assign pinCtrl[i].restart = restartVec[i];
    assign pinCtrl[i].sel     = {selHi[i], selLo[i]};
  end

  // R9: unused addresses leave the configuration untouched
  p_unused_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr > 3'd4) |=> ($stable(selHi) && $stable(selLo) && $stable(periods)));

  // R4: a period changes only on a write to its own address
  p_period_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == REG_PER_A) |=> $stable(periods[1]));

endmodule

// File: rtl/gpio_dbnc_datapath.sv
module gpio_dbnc_datapath
  import gpio_dbnc_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned CNT_W    = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_PINS-1:0]               rawIn,
  input  pinCtrl_t [NUM_PINS-1:0]           pinCtrl,
  input  logic [NUM_TIMERS:1][CNT_W-1:0]    periods,
  output logic [NUM_PINS-1:0]               filtOut
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [CNT_W-1:0] effPer, cnt, cntInc;
    logic             cand, outQ;

    assign effPer  = (pinCtrl[i].sel == 2'd0) ? '0 : periods[pinCtrl[i].sel];
    assign cntInc  = cnt + 1'b1;
    assign filtOut[i] = outQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outQ <= 1'b0;
        cand <= 1'b0;
        cnt  <= '0;
      end else if (pinCtrl[i].restart) begin
        cnt  <= '0;
        cand <= outQ;
      end else if (effPer == '0) begin
        outQ <= rawIn[i];
        cand <= rawIn[i];
        cnt  <= '0;
      end else if (rawIn[i] != cand) begin
        cand <= rawIn[i];
        cnt  <= '0;
      end else if (cnt >= effPer) begin
        outQ <= cand;
      end else begin
        cnt <= cntInc;
        if (cntInc >= effPer) outQ <= cand;
      end
    end

    // R3 / R7: zero effective period follows the raw sample
    p_bypass_follow_r3: assert property (@(posedge clk) disable iff (!rstN)
      (!pinCtrl[i].restart && effPer == '0) |=> (filtOut[i] == $past(rawIn[i])));

    // R8: selector change edge holds the output
    p_restart_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
      pinCtrl[i].restart |=> $stable(filtOut[i]));

    // R6: a fresh candidate never reaches the output on the same edge
    p_fresh_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      (!pinCtrl[i].restart && effPer != '0 && rawIn[i] != cand) |=> $stable(filtOut[i]));
  end

endmodule

// File: rtl/gpio_dbnc_filter.sv
module gpio_dbnc_filter
  import gpio_dbnc_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [2:0]          regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic [NUM_PINS-1:0] rawIn,
  output logic [NUM_PINS-1:0] filtOut
);

  pinCtrl_t [NUM_PINS-1:0]           pinCtrl;
  logic [NUM_TIMERS:1][CNT_W-1:0]    periods;

  gpio_dbnc_ctrl #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .pinCtrl(pinCtrl), .periods(periods)
  );

  gpio_dbnc_datapath #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .pinCtrl(pinCtrl),
    .periods(periods), .filtOut(filtOut)
  );

  // R1: output is cleared while reset is held
  always_comb begin
    if (!rstN) a_reset_zero_r1: assert (filtOut == '0);
  end

endmodule

// File: tb/gpio_dbnc_filter_tb.sv
module gpio_dbnc_filter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [2:0]    regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [NP-1:0] rawIn = '0;
  logic [NP-1:0] filtOut;

  int chkCnt = 0;
  int failCnt = 0;
  bit cmpOn = 1'b0;
  string curReq = "R1";

  // reference model state
  logic [NP-1:0] mOut, mCand, mSelHi, mSelLo;
  int mCnt [NP];
  int mPer [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_dbnc_filter dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .rawIn(rawIn), .filtOut(filtOut)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mOut = '0; mCand = '0; mSelHi = '0; mSelLo = '0;
      for (int i = 0; i < NP; i++) mCnt[i] = 0;
      for (int k = 0; k < 4; k++) mPer[k] = 0;
    end else begin
      logic [NP-1:0] nh, nl, rs;
      nh = (regWrEn && regAddr == 3'd0) ? regWrData : mSelHi;
      nl = (regWrEn && regAddr == 3'd1) ? regWrData : mSelLo;
      rs = (nh ^ mSelHi) | (nl ^ mSelLo);
      for (int i = 0; i < NP; i++) begin
        int s, p;
        s = {mSelHi[i], mSelLo[i]};
        p = (s == 0) ? 0 : mPer[s];
        if (rs[i]) begin
          mCnt[i] = 0; mCand[i] = mOut[i];
        end else if (p == 0) begin
          mOut[i] = rawIn[i]; mCand[i] = rawIn[i]; mCnt[i] = 0;
        end else if (rawIn[i] != mCand[i]) begin
          mCand[i] = rawIn[i]; mCnt[i] = 0;
        end else begin
          if (mCnt[i] < p) mCnt[i]++;
          if (mCnt[i] >= p) mOut[i] = mCand[i];
        end
      end
      mSelHi = nh; mSelLo = nl;
      if (regWrEn && regAddr >= 3'd2 && regAddr <= 3'd4)
        mPer[regAddr - 3'd1] = int'(regWrData[15:0]);
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      chkCnt++;
      if (filtOut !== mOut) begin
        failCnt++;
        $display("FAIL %s model compare: actual=%h expected=%h", curReq, filtOut, mOut);
      end
    end
  end

  task automatic check1(input string req, input logic act, input logic exp);
    chkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic randRun(input int n, input int maxHold);
    for (int k = 0; k < n; k++) begin
      rawIn = $urandom;
      repeat ($urandom_range(1, maxHold)) @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failCnt++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", chkCnt, failCnt);
    $finish;
  end

  initial begin
    logic keep;
    rawIn = 32'hA5C3_0F17;
    repeat (3) @(negedge clk);
    chkCnt++;
    if (filtOut !== '0) begin
      failCnt++;
      $display("FAIL R1: actual=%h expected=%h", filtOut, 32'h0);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chkCnt++;
    if (filtOut !== rawIn) begin
      failCnt++;
      $display("FAIL R10: actual=%h expected=%h", filtOut, rawIn);
    end
    cmpOn = 1'b1;

    curReq = "R3";
    randRun(20, 1);

    curReq = "R4";
    wr(3'd2, 32'hFFFF_0003);
    wr(3'd3, 32'd5);
    wr(3'd4, 32'd0);
    curReq = "R2";
    wr(3'd0, 32'h00FF_FF00);
    wr(3'd1, 32'h00FF_00FF);
    rawIn = '0;
    repeat (10) @(negedge clk);

    // R5: pin 0, period 3
    rawIn[0] = 1'b1;
    repeat (3) @(negedge clk);
    check1("R5 before period", filtOut[0], 1'b0);
    @(negedge clk);
    check1("R5 at period", filtOut[0], 1'b1);

    // R6: pin 8, period 5, pulse of 5 samples rejected
    rawIn[8] = 1'b1;
    repeat (5) @(negedge clk);
    rawIn[8] = 1'b0;
    repeat (8) @(negedge clk);
    check1("R6 short pulse", filtOut[8], 1'b0);

    // R7: pin 16, selector 3 with period 0
    rawIn[16] = 1'b1;
    @(negedge clk);
    check1("R7 zero period", filtOut[16], 1'b1);

    curReq = "R5";
    randRun(200, 8);

    // R8: pin 0 mid-count, selector 1 -> 0
    rawIn = '0;
    repeat (10) @(negedge clk);
    rawIn[0] = 1'b1;
    @(negedge clk);
    keep = filtOut[0];
    wr(3'd1, 32'h00FF_00FE);
    check1("R8 restart edge holds", filtOut[0], keep);
    @(negedge clk);
    check1("R8 new selector applies", filtOut[0], 1'b1);

    curReq = "R8";
    for (int k = 0; k < 30; k++) begin
      rawIn = $urandom;
      repeat ($urandom_range(1, 4)) @(negedge clk);
      wr(($urandom_range(0, 1) == 0) ? 3'd0 : 3'd1, $urandom);
    end

    curReq = "R9";
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'h1234_5678);
    wr(3'd7, 32'hFFFF_FFFF);
    randRun(60, 8);

    curReq = "R4";
    wr(3'd2, 32'd1);
    wr(3'd4, 32'd2);
    randRun(80, 6);

    cmpOn = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", chkCnt, failCnt);
    $finish;
  end

endmodule